// File: doc/BRIEF.md
# Programmable endian-swap region decoder

This block sits on the register access path between a processor and its peripherals. For every access it decides whether the 32-bit data word is byte-reversed. A processor whose byte order differs from the peripherals then sees every peripheral register with the same bit layout as a native processor would.

Software sets up to eight address windows through a small 32-bit configuration bus. Each window has a base register and a size register. The size register holds a 4-bit power-of-two code that spans 64KB to 128MB. A full-word access whose address falls inside any valid window has its write data reversed on the way out and its read data reversed on the way back. Every other access passes through untouched.

The swap decision is combinational on the access address. Configuration writes are registered, and each configuration request gets its response one cycle after the request.

Top module: `esw_region_decoder`

## Requirements
- R1: After reset, every configuration register reads as zero without error. Each region then has base 0 and size code 0 (64KB), so full-word accesses to addresses 0x0000_0000..0x0000_FFFF are swapped and an access at 0x0001_0000 is not.
- R2: The base register of region r sits at offset 8*r. Bits 31:8 are readable and writable. Bits 7:0 always read as zero and ignore writes.
- R3: The size register of region r sits at offset 8*r+4. Bits 3:0 hold the size code. Bits 31:4 always read as zero and ignore writes.
- R4: Size code c in the range 0..11 selects a window of 2^(16+c) bytes. An access matches region r when address bits 31:(16+c) equal the same bits of the base. The base bits below 16+c take no part in the compare.
- R5: A region whose size code is 12..15 never matches any address.
- R6: A matching access has acc_size = 2 (32-bit; 0 = byte, 1 = halfword, 3 = reserved). For it, acc_swap is 1, out_wdata = {acc_wdata[7:0], acc_wdata[15:8], acc_wdata[23:16], acc_wdata[31:24]}, and acc_rdata is per_rdata reversed the same way.
- R7: An access that matches no region, or that has acc_size other than 2, gives acc_swap = 0, out_wdata = acc_wdata and acc_rdata = per_rdata.
- R8: An address that falls inside several overlapping regions is reversed exactly once.
- R9: A configuration request gets cfg_rsp_valid high on the following cycle. A request at offset 64 or above, or at an offset with bits 1:0 not zero, responds with cfg_err = 1 and cfg_rdata = 0, and a write of that kind changes no register. A write response carries cfg_rdata = 0.
- R10: A configuration write changes the swap decision from the cycle after the write request. The decision during the request cycle itself still follows the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration request strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rsp_valid | output | 1 | Response valid, one cycle after the request |
| cfg_rdata | output | 32 | Read data of the response |
| cfg_err | output | 1 | Error response for an unmapped or unaligned offset |
| acc_addr | input | 32 | Address of the processor access |
| acc_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 reserved |
| acc_wdata | input | 32 | Write data from the processor |
| out_wdata | output | 32 | Write data toward the peripheral |
| per_rdata | input | 32 | Read data from the peripheral |
| acc_rdata | output | 32 | Read data toward the processor |
| acc_swap | output | 1 | The current access is byte-reversed |

## Verification
The assertions assume that a new configuration request arrives only while the previous response is being delivered. They also assume that the access inputs are stable for the whole cycle in which the swap decision is read. The bench issues one request per task and drives every access and configuration input at the falling edge of the clock, so both conditions hold. Outside the reset-state test, the bench parks each region it does not need at a distinct high 64KB window, so a check against one region cannot be disturbed by the others.

// File: rtl/esw_pkg.sv
package esw_pkg;

    localparam int NUM_REGIONS   = 8;
    localparam int ADDR_W        = 32;
    localparam int DATA_W        = 32;
    localparam int BASE_LSB      = 8;
    localparam int SIZE_W        = 4;
    localparam int MIN_WIN_LOG2  = 16;
    localparam int MAX_SIZE_CODE = 11;
    localparam int CFG_AW        = 8;
    localparam int BYTES_PER_REG = DATA_W / 8;

    typedef logic [ADDR_W-1:BASE_LSB] base_t;
    typedef logic [SIZE_W-1:0]        size_code_t;

    typedef struct packed {
        base_t      base;
        size_code_t code;
    } region_t;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic aligned;
        logic in_map;
        logic is_size;
    } cfg_dec_t;

    function automatic logic [DATA_W-1:0] byte_rev(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < BYTES_PER_REG; b++) begin
            r[8*b +: 8] = w[8*(BYTES_PER_REG-1-b) +: 8];
        end
        return r;
    endfunction

    function automatic logic code_valid(input size_code_t c);
        return int'(c) <= MAX_SIZE_CODE;
    endfunction

    function automatic logic [ADDR_W-1:0] window_mask(input size_code_t c);
        logic [ADDR_W-1:0] m;
        m = '1;
        m = m << (MIN_WIN_LOG2 + int'(c));
        return m;
    endfunction

endpackage

// File: rtl/esw_cfg_regs.sv
module esw_cfg_regs
    import esw_pkg::*;
#(
    parameter int N_REG = NUM_REGIONS,
    parameter int AW    = CFG_AW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_req,
    input  logic                    cfg_we,
    input  logic [AW-1:0]           cfg_addr,
    input  logic [DATA_W-1:0]       cfg_wdata,
    output logic                    cfg_rsp_valid,
    output logic [DATA_W-1:0]       cfg_rdata,
    output logic                    cfg_err,
    output region_t [N_REG-1:0]     regions
);

    localparam int IDX_W     = (N_REG > 1) ? $clog2(N_REG) : 1;
    localparam int MAP_BYTES = N_REG * 2 * BYTES_PER_REG;

    cfg_dec_t           dec;
    logic [IDX_W-1:0]   idx;
    logic               bad;
    logic [DATA_W-1:0]  rd_word;
    logic               unused_wbits;

    assign unused_wbits = ^cfg_wdata[BASE_LSB-1:SIZE_W];

    always_comb begin
        dec.aligned = (cfg_addr[1:0] == 2'b00);
        dec.in_map  = (int'(cfg_addr) < MAP_BYTES);
        dec.is_size = cfg_addr[2];
        idx         = cfg_addr[IDX_W+2:3];
        bad         = !(dec.aligned && dec.in_map);
    end

    always_comb begin
        rd_word = '0;
        for (int r = 0; r < N_REG; r++) begin
            if (int'(idx) == r) begin
                if (dec.is_size)
                    rd_word = {{(DATA_W-SIZE_W){1'b0}}, regions[r].code};
                else
                    rd_word = {regions[r].base, {BASE_LSB{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regions       <= '0;
            cfg_rsp_valid <= 1'b0;
            cfg_rdata     <= '0;
            cfg_err       <= 1'b0;
        end else begin
            cfg_rsp_valid <= cfg_req;
            if (cfg_req) begin
                cfg_err   <= bad;
                cfg_rdata <= (bad || cfg_we) ? '0 : rd_word;
                if (cfg_we && !bad) begin
                    for (int r = 0; r < N_REG; r++) begin
                        if (int'(idx) == r) begin
                            if (dec.is_size)
                                regions[r].code <= cfg_wdata[SIZE_W-1:0];
                            else
                                regions[r].base <= cfg_wdata[DATA_W-1:BASE_LSB];
                        end
                    end
                end
            end else begin
                cfg_err   <= 1'b0;
                cfg_rdata <= '0;
            end
        end
    end

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_req |=> cfg_rsp_valid);

    // R9
    no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_req |=> !cfg_rsp_valid);

    // R9
    err_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rsp_valid && cfg_err) |-> (cfg_rdata == '0));

    // R2
    base_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_we && !bad && !dec.is_size) |=> (cfg_rdata[BASE_LSB-1:0] == '0));

    // R3
    size_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_we && !bad && dec.is_size) |=> (cfg_rdata[DATA_W-1:SIZE_W] == '0));

    // R10
    size_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && cfg_we && !bad && dec.is_size && idx == '0)
            |=> (regions[0].code == $past(cfg_wdata[SIZE_W-1:0])));

endmodule

// File: rtl/esw_region_match.sv
module esw_region_match
    import esw_pkg::*;
#(
    parameter int N_REG = NUM_REGIONS
) (
    input  region_t [N_REG-1:0] regions,
    input  logic [ADDR_W-1:0]   addr,
    input  acc_size_e           size,
    output logic                swap
);

    logic [N_REG-1:0] hit;

    for (genvar g = 0; g < N_REG; g++) begin : g_win
        logic [ADDR_W-1:0] base_full;
        logic [ADDR_W-1:0] mask;
        logic              valid;

        always_comb begin
            base_full = {regions[g].base, {BASE_LSB{1'b0}}};
            mask      = window_mask(regions[g].code);
            valid     = code_valid(regions[g].code);
            hit[g]    = valid && (((addr ^ base_full) & mask) == '0);
        end

        always_comb begin
            // R5
            if (!valid) begin
                reserved_nohit_chk: assert (!hit[g]);
            end
        end
    end

    assign swap = (size == ACC_WORD) && (|hit);

    always_comb begin
        // R7
        if (size != ACC_WORD) begin
            narrow_noswap_chk: assert (!swap);
        end
    end

endmodule

// File: rtl/esw_swap_path.sv
module esw_swap_path
    import esw_pkg::*;
(
    input  logic              swap,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    output logic [DATA_W-1:0] out_wdata,
    output logic [DATA_W-1:0] acc_rdata
);

    always_comb begin
        out_wdata = swap ? byte_rev(acc_wdata) : acc_wdata;
        acc_rdata = swap ? byte_rev(per_rdata) : per_rdata;
    end

    always_comb begin
        // R6
        if (swap) begin
            swap_lanes_chk: assert (out_wdata[7:0] == acc_wdata[DATA_W-1:DATA_W-8]
                                 && acc_rdata[DATA_W-1:DATA_W-8] == per_rdata[7:0]);
        end
        // R7
        if (!swap) begin
            pass_through_chk: assert (out_wdata == acc_wdata && acc_rdata == per_rdata);
        end
    end

endmodule

// File: rtl/esw_region_decoder.sv
module esw_region_decoder
    import esw_pkg::*;
#(
    parameter int N_REG = NUM_REGIONS,
    parameter int AW    = CFG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              cfg_rsp_valid,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_err,
    input  logic [31:0]       acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       out_wdata,
    input  logic [31:0]       per_rdata,
    output logic [31:0]       acc_rdata,
    output logic              acc_swap
);

    region_t [N_REG-1:0] regions;
    acc_size_e           size_e;

    assign size_e = acc_size_e'(acc_size);

    esw_cfg_regs #(.N_REG(N_REG), .AW(AW)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .cfg_req       (cfg_req),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rdata     (cfg_rdata),
        .cfg_err       (cfg_err),
        .regions       (regions)
    );

    esw_region_match #(.N_REG(N_REG)) u_match (
        .regions (regions),
        .addr    (acc_addr),
        .size    (size_e),
        .swap    (acc_swap)
    );

    esw_swap_path u_path (
        .swap      (acc_swap),
        .acc_wdata (acc_wdata),
        .per_rdata (per_rdata),
        .out_wdata (out_wdata),
        .acc_rdata (acc_rdata)
    );

    // R8
    single_reverse_chk: assert property (@(posedge clk) disable iff (rst)
        acc_swap |-> (byte_rev(out_wdata) == acc_wdata));

endmodule

// File: tb/sim_esw_region_decoder.sv
module sim_esw_region_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        cfg_rsp_valid;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic [31:0] acc_addr;
    logic [1:0]  acc_size;
    logic [31:0] acc_wdata;
    logic [31:0] out_wdata;
    logic [31:0] per_rdata;
    logic [31:0] acc_rdata;
    logic        acc_swap;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_base [8];
    logic [3:0]  m_code [8];

    always #10 clk = ~clk;

    esw_region_decoder u0 (
        .clk(clk), .rst(rst),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .out_wdata(out_wdata), .per_rdata(per_rdata), .acc_rdata(acc_rdata),
        .acc_swap(acc_swap)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic bit model_swap(input logic [31:0] a, input logic [1:0] sz);
        bit any = 0;
        for (int r = 0; r < 8; r++) begin
            if (m_code[r] < 4'd12) begin
                int sh = 16 + int'(m_code[r]);
                if ((a >> sh) == (m_base[r] >> sh)) any = 1;
            end
        end
        return any && (sz == 2'd2);
    endfunction

    task automatic cfg_write(input logic [7:0] off, input logic [31:0] d, output logic err);
        @(negedge clk);
        cfg_req = 1; cfg_we = 1; cfg_addr = off; cfg_wdata = d;
        @(posedge clk); #5;
        err = cfg_err;
        cfg_req = 0; cfg_we = 0;
        if (off < 8'd64 && off[1:0] == 2'b00) begin
            if (off[2]) m_code[off[5:3]] = d[3:0];
            else        m_base[off[5:3]] = {d[31:8], 8'h00};
        end
    endtask

    task automatic cfg_read(input logic [7:0] off, output logic [31:0] d, output logic err);
        @(negedge clk);
        cfg_req = 1; cfg_we = 0; cfg_addr = off;
        @(posedge clk); #5;
        d = cfg_rdata; err = cfg_err;
        cfg_req = 0;
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] rd);
        bit s;
        @(negedge clk);
        acc_addr = a; acc_size = sz; acc_wdata = wd; per_rdata = rd;
        #2;
        s = model_swap(a, sz);
        check(req, "acc_swap", {31'b0, acc_swap}, {31'b0, s});
        check(req, "out_wdata", out_wdata, s ? rev(wd) : wd);
        check(req, "acc_rdata", acc_rdata, s ? rev(rd) : rd);
    endtask

    task automatic park_all();
        logic e;
        for (int r = 0; r < 8; r++) begin
            cfg_write(8'(8*r), 32'hF000_0000 | (32'(r) << 24), e);
            cfg_write(8'(8*r+4), 32'h0, e);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        for (int o = 0; o < 64; o += 4) begin
            cfg_read(8'(o), d, e);
            check("R1", "reset read", d, 32'h0);
            check("R1", "reset err", {31'b0, e}, 32'h0);
        end
        access("R1", 32'h0000_1000, 2'd2, 32'h1122_3344, 32'hA1B2_C3D4);
        access("R1", 32'h0000_FFFC, 2'd2, 32'h0102_0304, 32'h0);
        access("R1", 32'h0001_0000, 2'd2, 32'h1122_3344, 32'hA1B2_C3D4);
        check("R1", "swap at 0x1000 in reset state", {31'b0, model_swap(32'h1000, 2'd2)}, 32'h1);
    endtask

    task automatic t_fields();
        logic [31:0] d; logic e;
        cfg_write(8'h18, 32'hFFFF_FFFF, e);
        check("R2", "write err", {31'b0, e}, 32'h0);
        cfg_read(8'h18, d, e);
        check("R2", "base readback", d, 32'hFFFF_FF00);
        cfg_write(8'h1C, 32'hFFFF_FFF5, e);
        cfg_read(8'h1C, d, e);
        check("R3", "size readback", d, 32'h0000_0005);
        cfg_write(8'h08, 32'h1234_56AB, e);
        cfg_read(8'h08, d, e);
        check("R2", "base region1", d, 32'h1234_5600);
        cfg_read(8'h00, d, e);
        check("R2", "base region0 untouched", d, m_base[0]);
    endtask

    task automatic t_windows();
        logic e;
        park_all();
        cfg_write(8'h10, 32'h4012_3400, e);
        cfg_write(8'h14, 32'h4, e);
        access("R4", 32'h4010_0000, 2'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        access("R4", 32'h401F_FFFC, 2'd2, 32'h0011_2233, 32'h4455_6677);
        access("R4", 32'h4020_0000, 2'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        access("R4", 32'h400F_FFFC, 2'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        cfg_write(8'h18, 32'h8000_0000, e);
        cfg_write(8'h1C, 32'hB, e);
        access("R4", 32'h87FF_FFFC, 2'd2, 32'h8899_AABB, 32'hCCDD_EEFF);
        access("R4", 32'h8800_0000, 2'd2, 32'h8899_AABB, 32'hCCDD_EEFF);
        access("R4", 32'hF700_FFFC, 2'd2, 32'h0A0B_0C0D, 32'h0);
        access("R4", 32'hF701_0000, 2'd2, 32'h0A0B_0C0D, 32'h0);
        access("R6", 32'h4015_0000, 2'd2, 32'h1234_5678, 32'h9ABC_DEF0);
        check("R6", "reverse model", rev(32'h1234_5678), 32'h7856_3412);
    endtask

    task automatic t_reserved();
        logic e;
        park_all();
        cfg_write(8'h00, 32'h0, e);
        for (int c = 12; c < 16; c++) begin
            cfg_write(8'h04, 32'(c), e);
            access("R5", 32'h0000_0000, 2'd2, 32'h1122_3344, 32'h5566_7788);
            access("R5", 32'h0000_8000, 2'd2, 32'h1122_3344, 32'h5566_7788);
        end
        cfg_write(8'h04, 32'h0, e);
        access("R5", 32'h0000_8000, 2'd2, 32'h1122_3344, 32'h5566_7788);
    endtask

    task automatic t_overlap();
        logic e;
        park_all();
        cfg_write(8'h20, 32'h2000_0000, e);
        cfg_write(8'h28, 32'h2000_0000, e);
        cfg_write(8'h2C, 32'h3, e);
        access("R8", 32'h2000_1234, 2'd2, 32'hCAFE_0123, 32'h4567_89AB);
        access("R8", 32'h2004_0000, 2'd2, 32'hCAFE_0123, 32'h4567_89AB);
    endtask

    task automatic t_narrow();
        logic e;
        park_all();
        cfg_write(8'h30, 32'h5000_0000, e);
        access("R7", 32'h5000_0010, 2'd0, 32'h1122_3344, 32'h5566_7788);
        access("R7", 32'h5000_0010, 2'd1, 32'h1122_3344, 32'h5566_7788);
        access("R7", 32'h5000_0010, 2'd3, 32'h1122_3344, 32'h5566_7788);
        access("R7", 32'h6000_0010, 2'd2, 32'h1122_3344, 32'h5566_7788);
        access("R6", 32'h5000_0010, 2'd2, 32'h1122_3344, 32'h5566_7788);
    endtask

    task automatic t_bad_offset();
        logic [31:0] d; logic e;
        park_all();
        cfg_write(8'h40, 32'hFFFF_FFFF, e);
        check("R9", "err at 0x40", {31'b0, e}, 32'h1);
        cfg_read(8'h44, d, e);
        check("R9", "err at 0x44", {31'b0, e}, 32'h1);
        check("R9", "rdata on err", d, 32'h0);
        cfg_read(8'h06, d, e);
        check("R9", "err unaligned", {31'b0, e}, 32'h1);
        check("R9", "rdata unaligned", d, 32'h0);
        cfg_write(8'h02, 32'hFFFF_FFFF, e);
        check("R9", "err unaligned write", {31'b0, e}, 32'h1);
        cfg_write(8'hFC, 32'hFFFF_FFFF, e);
        cfg_read(8'h00, d, e);
        check("R9", "region0 base unchanged", d, m_base[0]);
        check("R9", "no err on good read", {31'b0, e}, 32'h0);
        cfg_read(8'h04, d, e);
        check("R9", "region0 size unchanged", d, 32'h0);
        @(negedge clk);
        cfg_req = 1; cfg_we = 1; cfg_addr = 8'h0C; cfg_wdata = 32'h3;
        @(posedge clk); #5;
        check("R9", "rsp valid on write", {31'b0, cfg_rsp_valid}, 32'h1);
        check("R9", "write rdata zero", cfg_rdata, 32'h0);
        cfg_req = 0; cfg_we = 0;
        m_code[1] = 4'h3;
        @(posedge clk); #5;
        check("R9", "rsp valid idle", {31'b0, cfg_rsp_valid}, 32'h0);
    endtask

    task automatic t_timing();
        park_all();
        @(negedge clk);
        cfg_req = 1; cfg_we = 1; cfg_addr = 8'h30; cfg_wdata = 32'h3000_0000;
        acc_addr = 32'h3000_0010; acc_size = 2'd2; acc_wdata = 32'hAABB_CCDD; per_rdata = 32'h0;
        #2;
        check("R10", "swap during write cycle", {31'b0, acc_swap}, 32'h0);
        check("R10", "wdata during write cycle", out_wdata, 32'hAABB_CCDD);
        @(posedge clk); #5;
        check("R10", "swap after write", {31'b0, acc_swap}, 32'h1);
        check("R10", "wdata after write", out_wdata, 32'hDDCC_BBAA);
        cfg_req = 0; cfg_we = 0;
        m_base[6] = 32'h3000_0000;
    endtask

    initial begin
        for (int r = 0; r < 8; r++) begin m_base[r] = 0; m_code[r] = 0; end
        rst = 1; cfg_req = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        acc_addr = 0; acc_size = 0; acc_wdata = 0; per_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_fields();
        t_windows();
        t_reserved();
        t_overlap();
        t_narrow();
        t_bad_offset();
        t_timing();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule